// File: doc/BRIEF.md
# Multi-Page-Size TLB Lookup Unit

This block is a fully associative translation lookaside buffer of 64 entries. Each entry holds a tag word and a translation word. A lookup presents a 64-bit virtual address and a 13-bit context. The block compares them against every entry at once. A matching entry yields a physical page address, a permission set and a protection verdict. Every entry carries its own page size: 8 KB, 64 KB, 512 KB or 4 MB. The page size decides how many address bits take part in the compare, and where the frame bits and the offset bits are joined.

A mode input selects a data lookup or an instruction lookup. In data mode both the privilege check and the write check apply. In instruction mode only the privilege check applies. On a miss the block records a fault tag word that joins the page-aligned virtual address with the context, and it raises a miss flag for the current mode. When translation is switched off, the virtual address passes straight through, truncated to the physical width. In instruction mode the same happens while the error-state flag is set. Software loads the entries through a write port that takes an index, a tag and a translation word.

Top module: `tlb_lookup`

## Requirements
- R1: An entry hits only when its translation word bit 63 (valid) is set, tag bits 12:0 equal ctx_i, and vaddr_i equals the tag in every bit the page-size mask keeps. Any of the 64 entries, index 0 to 63, can hit.
- R2: Translation word bits 62:61 give the page size: 0 means 8 KB, 1 means 64 KB, 2 means 512 KB and 3 means 4 MB. The compare ignores address bits below bit 13, 16, 19 or 22 respectively.
- R3: On a hit, paddr_o bits 40:13 come from the translation word above the page boundary and from vaddr_i below it. paddr_o bits 12:0 are zero.
- R4: In data mode a hit faults when translation bit 2 (privileged) is set and user_i is high, or when translation bit 1 (writable) is clear and write_i is high. A fault sets fault_o and hit_o and clears perm_o.
- R5: perm_o bit 0 means read, bit 1 means write and bit 2 means execute. A data hit without a fault grants read, and also grants write when translation bit 1 is set.
- R6: An instruction hit without a fault grants execute only. In instruction mode write_i and the writable bit have no effect.
- R7: On a miss, hit_o stays low and fault_tag_o is loaded with {vaddr_i[63:13], ctx_i}. dmiss_o is raised in data mode and imiss_o in instruction mode.
- R8: When mmu_en_i is low, or when inst_mode_i and red_state_i are both high, paddr_o is vaddr_i[40:0]. In that case hit_o, fault_o and the miss flags stay low and fault_tag_o keeps its value. perm_o is read plus write in data mode and execute in instruction mode.
- R9: When several entries hit, the entry with the lowest index gives the result.
- R10: A lookup strobed on req_i produces its results on the next cycle with valid_o high. In any cycle after a cycle without req_i, valid_o, hit_o, fault_o, dmiss_o and imiss_o are low.
- R11: A write takes effect for lookups strobed on the following cycle. A lookup strobed in the same cycle as a write sees the old contents.
- R12: Reset makes every entry invalid and clears all outputs.
- R13: fault_tag_o holds its value in every cycle that does not report a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 6 | Index of the entry to write |
| wr_tag_i | input | 64 | Tag word to store |
| wr_tte_i | input | 64 | Translation word to store |
| req_i | input | 1 | Lookup strobe |
| vaddr_i | input | 64 | Virtual address |
| ctx_i | input | 13 | Current context |
| inst_mode_i | input | 1 | 1 selects an instruction lookup, 0 a data lookup |
| write_i | input | 1 | The access is a write (data mode) |
| user_i | input | 1 | The access comes from user mode |
| mmu_en_i | input | 1 | Translation enable |
| red_state_i | input | 1 | Error-state flag; forces bypass in instruction mode |
| valid_o | output | 1 | A result is present |
| hit_o | output | 1 | A translation was found |
| fault_o | output | 1 | Protection fault on a hit |
| dmiss_o | output | 1 | Data lookup missed |
| imiss_o | output | 1 | Instruction lookup missed |
| paddr_o | output | 41 | Physical address |
| perm_o | output | 3 | Granted permissions {exec, write, read} |
| fault_tag_o | output | 64 | Page address and context of the last miss |

## Verification
The checker tests these rules on every cycle:
- outputs are registered one cycle after the strobe, and the flags are quiet when no lookup was made;
- at most one of hit, data miss and instruction miss is high at a time;
- a fault comes only with a hit and clears the permissions;
- the fault tag matches the strobed address and context on a miss, and holds otherwise;
- the low page bits of a hit address are zero;
- the permissions fit the mode;
- the bypass passes the address through.

Some behaviour only the bench scenarios can show:
- where each page size puts its compare boundary;
- how frame bits and offset bits merge;
- that the lowest-indexed entry wins among several hits;
- that context mismatches and invalid entries miss;
- that a write lands on the next cycle.

For these the bench compares the outputs against a reference model of the entry table.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 64;
  localparam int CTX_W      = 13;
  localparam int PA_W       = 41;
  localparam int PAGE_SHIFT = 13;
  localparam int SZ_STEP    = 3;

  // translation word layout
  localparam int TTE_VALID  = 63;
  localparam int TTE_SZ_HI  = 62;
  localparam int TTE_SZ_LO  = 61;
  localparam int TTE_PRIV   = 2;
  localparam int TTE_WRITE  = 1;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  typedef logic [VA_W-1:0] word_t;
  typedef logic [PA_W-1:0] paddr_t;
  typedef logic [2:0]      perm_t;

  typedef enum logic [1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_512K = 2'd2,
    PG_4M   = 2'd3
  } page_sz_e;

  // keeps address bits at and above the page boundary
  function automatic word_t page_mask(page_sz_e sz);
    return {VA_W{1'b1}} << (PAGE_SHIFT + SZ_STEP * int'(sz));
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  word_t                     wr_tag_i,
  input  word_t                     wr_tte_i,
  output logic [ENTRIES-1:0][VA_W-1:0] tag_o,
  output logic [ENTRIES-1:0][VA_W-1:0] tte_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_o[g] <= '0;
        tte_o[g] <= '0;
      end else if (sel) begin
        tag_o[g] <= wr_tag_i;
        tte_o[g] <= wr_tte_i;
      end
    end
  end
endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
  import tlb_pkg::*;
(
  input  word_t             tag_i,
  input  word_t             tte_i,
  input  word_t             va_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              hit_o,
  output paddr_t            pa_o,
  output logic              priv_o,
  output logic              wr_ok_o
);
  page_sz_e sz;
  word_t    mask;
  word_t    merged;

  assign sz     = page_sz_e'(tte_i[TTE_SZ_HI:TTE_SZ_LO]);
  assign mask   = page_mask(sz);
  assign hit_o  = tte_i[TTE_VALID]
               && (tag_i[CTX_W-1:0] == ctx_i)
               && (((va_i ^ tag_i) & mask) == '0);
  // frame from the translation word, offset from the virtual address
  assign merged = (tte_i & mask) | (va_i & ~mask);
  assign pa_o   = {merged[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign priv_o  = tte_i[TTE_PRIV];
  assign wr_ok_o = tte_i[TTE_WRITE];
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [63:0]       wr_tag_i,
  input  logic [63:0]       wr_tte_i,
  input  logic              req_i,
  input  logic [63:0]       vaddr_i,
  input  logic [12:0]       ctx_i,
  input  logic              inst_mode_i,
  input  logic              write_i,
  input  logic              user_i,
  input  logic              mmu_en_i,
  input  logic              red_state_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic              fault_o,
  output logic              dmiss_o,
  output logic              imiss_o,
  output logic [40:0]       paddr_o,
  output logic [2:0]        perm_o,
  output logic [63:0]       fault_tag_o
);
  logic [ENTRIES-1:0][VA_W-1:0] tag_q;
  logic [ENTRIES-1:0][VA_W-1:0] tte_q;
  logic [ENTRIES-1:0]           hit_vec;
  paddr_t                       pa_vec   [ENTRIES];
  logic [ENTRIES-1:0]           priv_vec;
  logic [ENTRIES-1:0]           wr_vec;
  logic                         found;
  logic [IDX_W-1:0]             sel_idx;

  tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_tag_i (wr_tag_i),
    .wr_tte_i (wr_tte_i),
    .tag_o    (tag_q),
    .tte_o    (tte_q)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    tlb_match_cell u_cell (
      .tag_i   (tag_q[g]),
      .tte_i   (tte_q[g]),
      .va_i    (vaddr_i),
      .ctx_i   (ctx_i),
      .hit_o   (hit_vec[g]),
      .pa_o    (pa_vec[g]),
      .priv_o  (priv_vec[g]),
      .wr_ok_o (wr_vec[g])
    );
  end

  tlb_prio_sel #(.ENTRIES(ENTRIES)) u_sel (
    .hit_i   (hit_vec),
    .found_o (found),
    .idx_o   (sel_idx)
  );

  logic   bypass;
  logic   sel_priv, sel_wr;
  paddr_t sel_pa;
  logic   prot_fault;
  perm_t  hit_perm;
  perm_t  byp_perm;

  assign bypass     = !mmu_en_i || (inst_mode_i && red_state_i);
  assign sel_pa     = pa_vec[sel_idx];
  assign sel_priv   = priv_vec[sel_idx];
  assign sel_wr     = wr_vec[sel_idx];
  assign prot_fault = (sel_priv && user_i)
                   || (!inst_mode_i && write_i && !sel_wr);

  always_comb begin
    hit_perm = '0;
    byp_perm = '0;
    if (inst_mode_i) begin
      hit_perm[PERM_EX] = 1'b1;
      byp_perm[PERM_EX] = 1'b1;
    end else begin
      hit_perm[PERM_RD] = 1'b1;
      hit_perm[PERM_WR] = sel_wr;
      byp_perm[PERM_RD] = 1'b1;
      byp_perm[PERM_WR] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      hit_o       <= 1'b0;
      fault_o     <= 1'b0;
      dmiss_o     <= 1'b0;
      imiss_o     <= 1'b0;
      paddr_o     <= '0;
      perm_o      <= '0;
      fault_tag_o <= '0;
    end else begin
      valid_o <= req_i;
      hit_o   <= 1'b0;
      fault_o <= 1'b0;
      dmiss_o <= 1'b0;
      imiss_o <= 1'b0;
      if (req_i) begin
        if (bypass) begin
          paddr_o <= vaddr_i[PA_W-1:0];
          perm_o  <= byp_perm;
        end else if (found) begin
          hit_o   <= 1'b1;
          fault_o <= prot_fault;
          paddr_o <= sel_pa;
          perm_o  <= prot_fault ? perm_t'('0) : hit_perm;
        end else begin
          dmiss_o     <= !inst_mode_i;
          imiss_o     <= inst_mode_i;
          paddr_o     <= '0;
          perm_o      <= '0;
          fault_tag_o <= {vaddr_i[VA_W-1:PAGE_SHIFT], ctx_i};
        end
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [63:0] vaddr_i,
  input logic [12:0] ctx_i,
  input logic        inst_mode_i,
  input logic        mmu_en_i,
  input logic        valid_o,
  input logic        hit_o,
  input logic        fault_o,
  input logic        dmiss_o,
  input logic        imiss_o,
  input logic [40:0] paddr_o,
  input logic [2:0]  perm_o,
  input logic [63:0] fault_tag_o
);
  // R10
  req_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(valid_o || hit_o || fault_o || dmiss_o || imiss_o));
  // R7
  outcome_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, dmiss_o, imiss_o}));
  // R4
  fault_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> hit_o && perm_o == 3'b000);
  // R7
  miss_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmiss_o || imiss_o) |-> fault_tag_o == {$past(vaddr_i[63:13]), $past(ctx_i)});
  // R7
  dmiss_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmiss_o |-> !$past(inst_mode_i));
  // R7
  imiss_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imiss_o |-> $past(inst_mode_i));
  // R6
  inst_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !fault_o && $past(inst_mode_i)) |-> perm_o == 3'b100);
  // R5
  data_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !fault_o && !$past(inst_mode_i)) |-> perm_o[0] && !perm_o[2]);
  // R3
  pa_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[12:0] == 13'd0);
  // R8
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !mmu_en_i) |=> !hit_o && !dmiss_o && !imiss_o
                              && paddr_o == $past(vaddr_i[40:0]));
  // R13
  ftag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmiss_o || imiss_o) |-> $stable(fault_tag_o));
endmodule

bind tlb_lookup tlb_lookup_chk u_chk (.*);

// File: tb/tlb_lookup_test.sv
module tlb_lookup_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_idx_i = '0;
  logic [63:0] wr_tag_i = '0;
  logic [63:0] wr_tte_i = '0;
  logic        req_i = 1'b0;
  logic [63:0] vaddr_i = '0;
  logic [12:0] ctx_i = '0;
  logic        inst_mode_i = 1'b0;
  logic        write_i = 1'b0;
  logic        user_i = 1'b0;
  logic        mmu_en_i = 1'b1;
  logic        red_state_i = 1'b0;
  logic        valid_o, hit_o, fault_o, dmiss_o, imiss_o;
  logic [40:0] paddr_o;
  logic [2:0]  perm_o;
  logic [63:0] fault_tag_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] m_tag [64];
  logic [63:0] m_tte [64];
  logic        e_hit, e_fault, e_dmiss, e_imiss;
  logic [40:0] e_pa;
  logic [2:0]  e_perm;
  logic [63:0] e_ftag;

  tlb_lookup uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input logic [1:0] sz);
    return ~64'd0 << (13 + 3 * int'(sz));
  endfunction

  // reference model of a lookup, evaluated against the model table
  task automatic model(input logic [63:0] va, input logic [12:0] ctx,
                       input bit inst, input bit wr, input bit usr,
                       input bit en, input bit red);
    int j;
    logic [63:0] m;
    logic [63:0] pf;
    bit flt;
    e_hit = 0; e_fault = 0; e_dmiss = 0; e_imiss = 0;
    if (!en || (inst && red)) begin
      e_pa   = va[40:0];
      e_perm = inst ? 3'b100 : 3'b011;
      return;
    end
    j = -1;
    for (int i = 0; i < 64; i++) begin
      m = mask_of(m_tte[i][62:61]);
      if (j < 0 && m_tte[i][63] && m_tag[i][12:0] == ctx
          && (va & m) == (m_tag[i] & m)) j = i;
    end
    if (j < 0) begin
      e_pa = '0; e_perm = '0;
      e_ftag = {va[63:13], ctx};
      e_dmiss = !inst; e_imiss = inst;
      return;
    end
    m  = mask_of(m_tte[j][62:61]);
    pf = ((m_tte[j] & m) | (va & ~m)) & 64'h1FF_FFFF_E000;
    flt = (m_tte[j][2] && usr) || (!inst && wr && !m_tte[j][1]);
    e_hit = 1; e_fault = flt; e_pa = pf[40:0];
    if (flt) e_perm = 3'b000;
    else if (inst) e_perm = 3'b100;
    else e_perm = {1'b0, m_tte[j][1], 1'b1};
  endtask

  task automatic compare(input string req);
    chk(valid_o == 1'b1, req, "valid", 64'(valid_o), 64'd1);
    chk(hit_o == e_hit, req, "hit", 64'(hit_o), 64'(e_hit));
    chk(fault_o == e_fault, req, "fault", 64'(fault_o), 64'(e_fault));
    chk(dmiss_o == e_dmiss, req, "dmiss", 64'(dmiss_o), 64'(e_dmiss));
    chk(imiss_o == e_imiss, req, "imiss", 64'(imiss_o), 64'(e_imiss));
    chk(paddr_o == e_pa, req, "paddr", 64'(paddr_o), 64'(e_pa));
    chk(perm_o == e_perm, req, "perm", 64'(perm_o), 64'(e_perm));
    chk(fault_tag_o == e_ftag, req, "fault_tag", fault_tag_o, e_ftag);
  endtask

  task automatic write_entry(input int idx, input logic [63:0] tag,
                             input logic [63:0] tte);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 6'(idx); wr_tag_i = tag; wr_tte_i = tte;
    @(negedge clk_i);
    wr_en_i = 0;
    m_tag[idx] = tag; m_tte[idx] = tte;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [12:0] ctx,
                        input bit inst, input bit wr, input bit usr,
                        input bit en, input bit red, input string req);
    @(negedge clk_i);
    vaddr_i = va; ctx_i = ctx; inst_mode_i = inst; write_i = wr;
    user_i = usr; mmu_en_i = en; red_state_i = red; req_i = 1;
    model(va, ctx, inst, wr, usr, en, red);
    @(negedge clk_i);
    req_i = 0;
    compare(req);
  endtask

  function automatic logic [63:0] tte_mk(input logic [1:0] sz,
                                         input logic [63:0] frame,
                                         input bit priv, input bit wr);
    return {1'b1, sz, 61'd0} | (frame & 64'h1FF_FFFF_E000)
           | {61'd0, priv, wr, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    e_ftag = '0;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk(valid_o == 0 && hit_o == 0 && dmiss_o == 0 && imiss_o == 0, "R12",
        "flags", {59'd0, valid_o, hit_o, fault_o, dmiss_o, imiss_o}, 64'd0);
    chk(paddr_o == 0 && perm_o == 0 && fault_tag_o == 0, "R12", "data",
        64'(paddr_o) ^ fault_tag_o, 64'd0);
    rst_ni = 1;
    // R12 all entries invalid: a zero tag with zero context still misses
    lookup(64'h0, 13'd0, 0, 0, 0, 1, 0, "R12");
    chk(dmiss_o == 1, "R12", "invalid entry miss", 64'(dmiss_o), 64'd1);

    // R2 R3 one entry per page size, same context
    write_entry(0, 64'h0000_1234_5678_A000 | 64'd5, tte_mk(2'd0, 64'h0AB_CDEF_2000, 0, 1));
    write_entry(1, 64'h0000_2222_0001_0000 | 64'd5, tte_mk(2'd1, 64'h155_5555_0000, 0, 1));
    write_entry(2, 64'h0000_3333_0008_0000 | 64'd5, tte_mk(2'd2, 64'h0F0_F0F8_0000, 0, 1));
    write_entry(3, 64'h0000_4444_0040_0000 | 64'd5, tte_mk(2'd3, 64'h1AB_CDC0_0000, 0, 1));
    lookup(64'h0000_1234_5678_BFFF, 13'd5, 0, 0, 0, 1, 0, "R2");
    chk(paddr_o == 41'h0AB_CDEF_2000, "R3", "8K paddr", 64'(paddr_o), 64'h0AB_CDEF_2000);
    lookup(64'h0000_1234_5678_C000, 13'd5, 0, 0, 0, 1, 0, "R2");
    lookup(64'h0000_2222_0001_FFFF, 13'd5, 0, 0, 0, 1, 0, "R2");
    chk(paddr_o == 41'h155_5555_E000, "R3", "64K paddr", 64'(paddr_o), 64'h155_5555_E000);
    lookup(64'h0000_2222_0002_0000, 13'd5, 0, 0, 0, 1, 0, "R2");
    lookup(64'h0000_3333_000F_E123, 13'd5, 0, 0, 0, 1, 0, "R2");
    lookup(64'h0000_3333_0010_0000, 13'd5, 0, 0, 0, 1, 0, "R2");
    lookup(64'h0000_4444_007F_FFFF, 13'd5, 0, 0, 0, 1, 0, "R3");
    chk(paddr_o == 41'h1AB_CDFF_E000, "R3", "4M paddr", 64'(paddr_o), 64'h1AB_CDFF_E000);
    lookup(64'h0000_4444_0080_0000, 13'd5, 1, 0, 0, 1, 0, "R7");
    chk(imiss_o == 1, "R7", "imiss", 64'(imiss_o), 64'd1);
    // R1 context mismatch misses, highest index hits
    lookup(64'h0000_1234_5678_A000, 13'd6, 0, 0, 0, 1, 0, "R1");
    chk(fault_tag_o == 64'h0000_1234_5678_A006, "R7", "fault tag", fault_tag_o,
        64'h0000_1234_5678_A006);
    write_entry(63, 64'h7FFF_0000_0000_2000 | 64'd9, tte_mk(2'd0, 64'h000_0000_4000, 0, 0));
    lookup(64'h7FFF_0000_0000_2ABC, 13'd9, 0, 0, 0, 1, 0, "R1");

    // R4 R5 R6 protection
    write_entry(4, 64'h0000_5555_0000_0000 | 64'd7, tte_mk(2'd0, 64'h011_1111_0000, 1, 0));
    lookup(64'h0000_5555_0000_0010, 13'd7, 0, 0, 1, 1, 0, "R4");
    chk(fault_o == 1 && perm_o == 0, "R4", "user fault", 64'(perm_o), 64'd0);
    lookup(64'h0000_5555_0000_0010, 13'd7, 0, 1, 0, 1, 0, "R4");
    lookup(64'h0000_5555_0000_0010, 13'd7, 0, 0, 0, 1, 0, "R5");
    chk(perm_o == 3'b001, "R5", "read only", 64'(perm_o), 64'd1);
    lookup(64'h0000_1234_5678_A000, 13'd5, 0, 1, 1, 1, 0, "R5");
    chk(perm_o == 3'b011, "R5", "read write", 64'(perm_o), 64'd3);
    lookup(64'h0000_5555_0000_0010, 13'd7, 1, 1, 0, 1, 0, "R6");
    chk(fault_o == 0 && perm_o == 3'b100, "R6", "exec ignores write",
        64'(perm_o), 64'd4);
    lookup(64'h0000_5555_0000_0010, 13'd7, 1, 0, 1, 1, 0, "R6");

    // R9 duplicate match, lowest index wins
    write_entry(40, 64'h0000_6666_0000_0000 | 64'd3, tte_mk(2'd0, 64'h000_AAAA_0000, 0, 1));
    write_entry(10, 64'h0000_6666_0000_0000 | 64'd3, tte_mk(2'd1, 64'h000_BBBB_0000, 0, 0));
    lookup(64'h0000_6666_0000_1000, 13'd3, 0, 0, 0, 1, 0, "R9");
    chk(paddr_o == 41'h000_BBBB_0000, "R9", "low index", 64'(paddr_o), 64'h000_BBBB_0000);
    write_entry(10, '0, '0);
    lookup(64'h0000_6666_0000_1000, 13'd3, 0, 0, 0, 1, 0, "R9");

    // R8 bypass
    lookup(64'hFFFF_FFFF_FFFF_FFFF, 13'd1, 0, 0, 0, 0, 0, "R8");
    chk(paddr_o == 41'h1FF_FFFF_FFFF, "R8", "pass through", 64'(paddr_o), 64'h1FF_FFFF_FFFF);
    lookup(64'h0000_0000_0012_3456, 13'd1, 1, 0, 0, 1, 1, "R8");
    lookup(64'h0000_5555_0000_0010, 13'd7, 0, 1, 1, 1, 1, "R8");

    // R11 write and lookup in the same cycle
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 6'd0; wr_tag_i = 64'h0000_1234_5678_A000 | 64'd5;
    wr_tte_i = tte_mk(2'd0, 64'h077_7777_0000, 0, 1);
    vaddr_i = 64'h0000_1234_5678_A000; ctx_i = 13'd5; inst_mode_i = 0;
    write_i = 0; user_i = 0; mmu_en_i = 1; red_state_i = 0; req_i = 1;
    model(vaddr_i, ctx_i, 0, 0, 0, 1, 0);
    @(negedge clk_i);
    wr_en_i = 0; req_i = 0;
    compare("R11");
    m_tag[0] = 64'h0000_1234_5678_A000 | 64'd5;
    m_tte[0] = tte_mk(2'd0, 64'h077_7777_0000, 0, 1);
    lookup(64'h0000_1234_5678_A000, 13'd5, 0, 0, 0, 1, 0, "R11");
    chk(paddr_o == 41'h077_7777_0000, "R11", "new entry", 64'(paddr_o), 64'h077_7777_0000);

    // R10 idle cycle clears the flags
    @(negedge clk_i);
    chk(!(valid_o || hit_o || dmiss_o || imiss_o || fault_o), "R10", "idle flags",
        {59'd0, valid_o, hit_o, fault_o, dmiss_o, imiss_o}, 64'd0);

    // R13 random table and traffic
    for (int i = 0; i < 64; i++) begin
      logic [63:0] t;
      logic [63:0] v;
      t = {$urandom, $urandom};
      v = {$urandom, $urandom};
      v[63] = ($urandom_range(0, 7) != 0);
      write_entry(i, {t[63:13], 13'($urandom_range(0, 3))}, v);
    end
    for (int k = 0; k < 1500; k++) begin
      int j;
      logic [63:0] va;
      logic [63:0] m;
      logic [12:0] c;
      j  = $urandom_range(0, 63);
      m  = mask_of(m_tte[j][62:61]);
      va = (m_tag[j] & m) | ({$urandom, $urandom} & ~m);
      c  = ($urandom_range(0, 4) == 0) ? 13'($urandom_range(0, 3)) : m_tag[j][12:0];
      if ($urandom_range(0, 9) == 0) va = {$urandom, $urandom};
      lookup(va, c, 1'($urandom), 1'($urandom), 1'($urandom),
             ($urandom_range(0, 15) != 0), ($urandom_range(0, 7) == 0), "R13");
      if ($urandom_range(0, 19) == 0)
        write_entry($urandom_range(0, 63), {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule